// File: doc/BRIEF.md
# Interleaved Modular Multiplier

This block computes the product of two field elements modulo a modulus supplied at run time. It serves as the arithmetic core for prime-field elliptic-curve work. All operands are handled as single full-width words; they are never split into smaller limbs. The multiplier operand is scanned one bit per cycle, starting at its top bit. In each cycle the running remainder is doubled, the multiplicand is added when the scanned bit is set, and the sum is reduced in the same step. That reduction uses two subtractor candidates evaluated in parallel. One closing cycle applies a conditional subtraction of the modulus before the result is presented.

The caller places `op_a`, `op_b` and `modulus` on the inputs and strobes `start` for one cycle while `busy` is low. The operands are captured on that edge. `busy` stays high while the operation runs. After exactly W+1 clock edges, `done` pulses for one cycle and `result` carries the product. `result` then holds until a later operation overwrites it. The block has no back-pressure and no queue. A `start` that arrives while `busy` is high is dropped. The caller must keep `op_a` and `op_b` below `modulus`.

Top module: `modmul_core`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `result` are all 0.
- R2: For any `modulus` P with 2 <= P < 2^W and any `op_a`, `op_b` below P, `result` equals op_a*op_b mod P in the cycle where `done` is high.
- R3: Whenever `done` is high, `result` is below the modulus captured at start.
- R4: `done` rises exactly W+1 clock edges after the edge that accepted `start`. This count is the same for every operand and modulus value.
- R5: `done` is high for exactly one cycle per operation.
- R6: A `start` asserted while `busy` is high has no effect: the running operation keeps its operands, its result and its timing.
- R7: `result` changes only on the edge where `done` rises. Otherwise it holds its previous value.
- R8: During an operation, the internal running remainder always stays below the modulus.
- R9: A reset asserted during an operation aborts it. `busy` and `done` fall, no `done` pulse follows, and the next started operation completes normally.
- R10: `busy` is high from the cycle after an accepted `start` up to the cycle before `done`, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin; ignored while busy |
| op_a | input | W | Multiplier operand, scanned MSB first |
| op_b | input | W | Multiplicand operand |
| modulus | input | W | Runtime modulus P |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | op_a*op_b mod P, held after done |

## Verification
The hardest case to reach from the ports is a running remainder near the top of the range. There the doubled sum plus the multiplicand comes close to three times the modulus, so the T−2P candidate must be chosen. The bench forces this with operands equal to P−1 and with moduli whose top bit is set, so the guard bits are exercised. A second hard case is a `start` that lands in the middle of an operation and carries different operands. The bench drives one such request about ten cycles into a run and then checks that the original product arrives on schedule.

// File: rtl/modmul_pkg.sv
package modmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIN  = 2'd2
  } mm_state_e;
endpackage

// File: rtl/modmul_step.sv
module modmul_step #(
  parameter int W = 256
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mod_p,
  input  logic         a_bit,
  output logic [W-1:0] rem_out
);
  localparam int GW = W + 3;

  logic [GW-1:0] sum_t;
  logic [GW-1:0] pe;
  logic [GW-1:0] cand [1:2];

  // accumulation adder: 2R + (a_i ? B : 0), mask instead of branch
  always_comb begin
    pe    = {3'b000, mod_p};
    sum_t = {2'b00, rem_in, 1'b0} + {3'b000, mcand & {W{a_bit}}};
  end

  // two reduction adders working in parallel: T-P and T-2P
  for (genvar k = 1; k <= 2; k++) begin : g_red
    always_comb cand[k] = sum_t - (pe << (k - 1));
  end

  // smallest non-negative candidate wins; sign bit is the guard MSB
  always_comb begin
    if (!cand[2][GW-1])      rem_out = cand[2][W-1:0];
    else if (!cand[1][GW-1]) rem_out = cand[1][W-1:0];
    else                     rem_out = sum_t[W-1:0];
  end
endmodule

// File: rtl/modmul_final.sv
module modmul_final #(
  parameter int W = 256
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] mod_p,
  output logic [W-1:0] red_out
);
  logic [W:0] diff;

  always_comb begin
    diff    = {1'b0, rem_in} - {1'b0, mod_p};
    red_out = diff[W] ? rem_in : diff[W-1:0];
  end
endmodule

// File: rtl/modmul_ctrl.sv
module modmul_ctrl
  import modmul_pkg::*;
#(
  parameter int W = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic iter,
  output logic fin
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mm_state_e       state_q;
  logic [CW-1:0]   cnt_q;

  always_comb begin
    busy = (state_q != ST_IDLE);
    load = (state_q == ST_IDLE) && start;
    iter = (state_q == ST_ITER);
    fin  = (state_q == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_ITER;
          cnt_q   <= '0;
        end
        ST_ITER: begin
          if (cnt_q == LAST) state_q <= ST_FIN;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: fin always follows the last iteration
  a_r10_fin_after_iter: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(iter));
endmodule

// File: rtl/modmul_core.sv
module modmul_core #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] modulus,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int LW = $clog2(W + 2) + 1;

  logic         load, iter, fin;
  logic [W-1:0] a_q, b_q, p_q, r_q, res_q;
  logic [W-1:0] r_next, r_final;
  logic         done_q;
  logic [LW-1:0] lat_q;

  modmul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .load(load), .iter(iter), .fin(fin)
  );

  modmul_step #(.W(W)) u_step (
    .rem_in(r_q), .mcand(b_q), .mod_p(p_q), .a_bit(a_q[W-1]),
    .rem_out(r_next)
  );

  modmul_final #(.W(W)) u_final (
    .rem_in(r_q), .mod_p(p_q), .red_out(r_final)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      r_q    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        a_q <= op_a;
        b_q <= op_b;
        p_q <= modulus;
        r_q <= '0;
      end else if (iter) begin
        r_q <= r_next;
        a_q <= a_q << 1;
      end else if (fin) begin
        res_q  <= r_final;
        done_q <= 1'b1;
      end
    end
  end

  assign done   = done_q;
  assign result = res_q;

  // latency counter kept apart from the control counter, for checking only
  always_ff @(posedge clk) begin
    if (rst)       lat_q <= '0;
    else if (load) lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  a_r3_result_below_mod: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < p_q));
  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LW'(W + 1)));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(p_q) && $stable(b_q)));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
  a_r8_remainder_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (r_q < p_q));
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/modmul_core_test.sv
module modmul_core_test;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  longint start_cyc = 0;
  logic [W-1:0] exp_q [$];

  modmul_core #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .modulus(modulus), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, b, p);
    logic [2*W-1:0] prod;
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    prod = prod % {{W{1'b0}}, p};
    return prod[W-1:0];
  endfunction

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] v = '0;
    for (int i = 0; i < W / 32; i++) v = {v[W-33:0], $urandom()};
    return v;
  endfunction

  // driver: push expected value, pulse start, wait for completion
  task automatic run_op(input logic [W-1:0] a, b, p);
    exp_q.push_back(ref_mul(a, b, p));
    @(negedge clk);
    op_a = a; op_b = b; modulus = p; start = 1'b1;
    @(posedge clk);
    #1 start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pop and compare on each done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      logic [W-1:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
      check(result == e, "R2 product", result, e);
      check(result < modulus, "R3 below modulus", result, modulus);
      check((cyc - start_cyc) == W + 1, "R4 latency",
            W'(cyc - start_cyc), W'(W + 1));
    end
  end

  // R5/R7: the cycle after done, done is low and result unchanged
  logic [W-1:0] last_res;
  always @(negedge clk) begin
    if (!rst && done) begin
      last_res = result;
      @(negedge clk);
      check(!done, "R5 done pulse", W'(done), '0);
      check(result == last_res, "R7 result hold", result, last_res);
    end
  end

  localparam logic [W-1:0] P256 =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && result == '0, "R1 reset state", result, '0);
    rst = 1'b0;
    @(negedge clk);

    run_op(256'd5, 256'd7, 256'd13);
    run_op(256'd0, 256'd12, 256'd13);
    run_op(256'd1, 256'd1, 256'd2);
    run_op(P256 - 1, P256 - 1, P256);
    run_op(P256 - 1, 256'd1, P256);
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] a = rnd_word(), b = rnd_word();
      run_op(a % P256, b % P256, P256);
    end
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] p = rnd_word() | {1'b1, {(W-1){1'b0}}} | 1;
      run_op(p - 1, rnd_word() % p, p);
    end
    for (int i = 0; i < 4; i++) begin
      logic [W-1:0] p = (rnd_word() >> (i * 60)) | 256'd3;
      run_op(rnd_word() % p, rnd_word() % p, p);
    end

    // R6: start while busy with other operands
    exp_q.push_back(ref_mul(256'd1234567, 256'd7654321, P256));
    @(negedge clk);
    op_a = 256'd1234567; op_b = 256'd7654321; modulus = P256; start = 1'b1;
    @(posedge clk);
    #1 start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    op_a = 256'd3; op_b = 256'd4; modulus = 256'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R6 still busy", W'(busy), 1);
    op_a = 256'd1234567; op_b = 256'd7654321; modulus = P256;
    while (!done) @(negedge clk);
    @(negedge clk);

    // R9: reset in the middle of an operation
    @(negedge clk);
    op_a = 256'd11; op_b = 256'd9; modulus = 256'd97; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R9 abort flags", {254'b0, busy, done}, '0);
    check(result == '0, "R9 result cleared", result, '0);
    rst = 1'b0;
    begin
      bit seen = 1'b0;
      repeat (300) begin
        @(negedge clk);
        if (done || busy) seen = 1'b1;
      end
      check(!seen, "R9 no late done", W'(seen), '0);
    end
    run_op(256'd11, 256'd9, 256'd97);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule